// File: doc/BRIEF.md
# Device Interrupt Pin Mapping Registers

This block holds the routing of the four interrupt pins (A, B, C, D) of each device on a shared bus onto eight shared interrupt lines, numbered 0 to 7 (lines A to H). Devices 25 to 31 each own a 16-bit mapping register in a 16-byte memory-mapped window. The window is byte-granular and little-endian. It is reached through a single 32-bit access port with byte enables, a write strobe and a read strobe. Every register is decoded continuously into a 3-bit line number per device and pin, and this map is presented as a flat vector.

Device 30 is hard-wired. Its register is always zero, and its pins A to D always land on lines 4 to 7. Any device number outside 25 to 31 gets a fixed rotation that uses only the upper four lines, which leaves lines 0 to 3 free for other sources. A combinational lookup port returns the line for any device number and pin. Every write access is followed by a one-cycle routing-changed pulse, so that consumers of the map can re-evaluate it.

Top module: `pirq_route_top`

## Requirements
- R1: After reset, the registers of devices 25 to 29 and 31 read 0x3210 (pin n maps to line n), device 30 reads 0, bytes 14 and 15 read 0, and routeChanged and rdValid are low.
- R2: The register of device d occupies window bytes 2*(d-25) (bits 7:0) and 2*(d-25)+1 (bits 15:8). Pin n of a device uses register bits [4n+3:4n], and the 32-bit data lane k carries window byte offset+k.
- R3: A write changes only the bytes whose byteEn lane bit is set.
- R4: Only the low 4 bits of addr form the byte offset, so addresses that differ only above bit 3 reach the same bytes.
- R5: Lanes whose byte offset+k passes byte 15 are clipped: a write drops them, a read returns 0 in them, and no access wraps to byte 0.
- R6: Writes to device 30's bytes (10 and 11) are ignored, they read as 0, and its pins A to D always map to lines 4, 5, 6 and 7.
- R7: The decoded line for a pin is bits [2:0] of its nibble. Bit 3 is stored and reads back as written, but it does not affect the decode.
- R8: For a lookup device number outside 25 to 31, pin p of device s maps to line ((s + p) mod 4) + 4.
- R9: The lookup port is combinational and, for devices 25 to 31, returns the same line as the decoded map for that device and pin (pin encoding A=0 to D=3).
- R10: routeChanged is high for exactly the one cycle after each cycle that has wrEn high, and is low at all other times.
- R11: rdData and rdValid update on the cycle after rdEn. A read issued in the same cycle as a write returns the bytes as they were before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for one access |
| rdEn | input | 1 | Read strobe for one access |
| addr | input | 8 | Byte address; the low 4 bits select the window byte |
| wrData | input | 32 | Write data, lane k for byte offset+k |
| byteEn | input | 4 | Per-lane write enables |
| rdData | output | 32 | Read data, registered |
| rdValid | output | 1 | rdData holds the result of the previous cycle's read |
| pinMap | output | 84 | Decoded lines, 3 bits per (device 25..31, pin 0..3), index ((d-25)*4+pin)*3 |
| lookupDev | input | 5 | Device number to look up |
| lookupPin | input | 2 | Pin to look up (A=0 .. D=3) |
| lookupPirq | output | 3 | Line for the looked-up device and pin |
| routeChanged | output | 1 | One-cycle pulse after each write |

## Verification
The assertions check on every cycle:
- the pulse relation between writes and routeChanged, and between rdEn and rdValid;
- that the map stays still when there is no write;
- that lookups outside the register range always land in the upper half of the lines;
- that lookups inside the range agree with the decoded map.

Some behaviours depend on the contents of the window, and only the bench's scenarios can show them: byte placement, lane clipping, the address mask, ignored writes to device 30, the reserved nibble bit and read-before-write ordering. The bench compares these against a byte-level model of the window after both random and directed accesses.

// File: rtl/pirq_route_pkg.sv
package pirq_route_pkg;
  localparam int WIN_BYTES = 16;
  localparam int OFF_W = $clog2(WIN_BYTES);
  localparam int LANES = 4;
  localparam int LANE_W = $clog2(LANES);
  localparam int DEV_FIRST = 25;
  localparam int DEV_COUNT = 7;
  localparam int FIXED_DEV = 30;
  localparam int PIN_COUNT = 4;
  localparam int PIN_W = $clog2(PIN_COUNT);
  localparam int NUM_PIRQ = 8;
  localparam int PIRQ_W = $clog2(NUM_PIRQ);
  localparam int HALF_PIRQ = NUM_PIRQ / 2;
  localparam int NIB_W = 4;
  localparam int REG_BYTES = 2;
  localparam int DEV_W = 5;
  localparam int MAP_W = DEV_COUNT * PIN_COUNT * PIRQ_W;
  localparam logic [15:0] DEFAULT_MAP = 16'h3210;

  // strobes from control to datapath
  typedef struct packed {
    logic [WIN_BYTES-1:0] byteWe;
    logic [OFF_W-1:0]     base;
    logic                 rdLoad;
  } winStrobe_t;
endpackage

// File: rtl/pirq_route_ctrl.sv
module pirq_route_ctrl
  import pirq_route_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  byteEn,
  output winStrobe_t        strobe,
  output logic              routeChanged,
  output logic              rdValid
);
  logic [OFF_W-1:0] offset;
  assign offset = addr[OFF_W-1:0];

  // map lanes onto window bytes; lanes past the end are clipped
  always_comb begin
    strobe.byteWe = '0;
    strobe.base   = offset;
    strobe.rdLoad = rdEn;
    for (int k = 0; k < LANES; k++) begin
      logic [OFF_W:0] tgt;
      tgt = {1'b0, offset} + (OFF_W+1)'(k);
      if (wrEn && byteEn[k] && !tgt[OFF_W])
        strobe.byteWe[tgt[OFF_W-1:0]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      routeChanged <= 1'b0;
      rdValid      <= 1'b0;
    end else begin
      routeChanged <= wrEn;
      rdValid      <= rdEn;
    end
  end
endmodule

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_route_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  winStrobe_t          strobe,
  input  logic [LANES*8-1:0]  wrData,
  output logic [LANES*8-1:0]  rdData,
  output logic [MAP_W-1:0]    pinMap
);
  localparam int REG_SPAN = DEV_COUNT * REG_BYTES;
  localparam int FIXED_IDX = FIXED_DEV - DEV_FIRST;

  logic [7:0] winByte [WIN_BYTES];

  for (genvar b = 0; b < WIN_BYTES; b++) begin : gByte
    if (b < REG_SPAN && (b / REG_BYTES) == FIXED_IDX) begin : gFixed
      assign winByte[b] = 8'h00;
    end else begin : gStore
      localparam logic [7:0] RST_VAL =
        (b >= REG_SPAN) ? 8'h00 : DEFAULT_MAP[(b % REG_BYTES)*8 +: 8];
      logic [OFF_W-1:0]  rel;
      logic [LANE_W-1:0] lane;
      logic [7:0]        q;
      assign rel  = OFF_W'(b) - strobe.base;
      assign lane = rel[LANE_W-1:0];
      always_ff @(posedge clk) begin
        if (!rstN)                q <= RST_VAL;
        else if (strobe.byteWe[b]) q <= wrData[lane*8 +: 8];
      end
      assign winByte[b] = q;
    end
  end

  // registered read, clipped lanes return zero
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobe.rdLoad) begin
      for (int k = 0; k < LANES; k++) begin
        logic [OFF_W:0] tgt;
        tgt = {1'b0, strobe.base} + (OFF_W+1)'(k);
        rdData[k*8 +: 8] <= tgt[OFF_W] ? 8'h00 : winByte[tgt[OFF_W-1:0]];
      end
    end
  end

  // per-device, per-pin decode
  for (genvar d = 0; d < DEV_COUNT; d++) begin : gDev
    logic [15:0] regVal;
    assign regVal = {winByte[d*REG_BYTES+1], winByte[d*REG_BYTES]};
    for (genvar p = 0; p < PIN_COUNT; p++) begin : gPin
      if (d == FIXED_IDX) begin : gHard
        assign pinMap[(d*PIN_COUNT+p)*PIRQ_W +: PIRQ_W] = PIRQ_W'(HALF_PIRQ + p);
      end else begin : gDecode
        assign pinMap[(d*PIN_COUNT+p)*PIRQ_W +: PIRQ_W] = regVal[p*NIB_W +: PIRQ_W];
      end
    end
  end
endmodule

// File: rtl/pirq_route_lookup.sv
module pirq_route_lookup
  import pirq_route_pkg::*;
(
  input  logic [DEV_W-1:0]  lookupDev,
  input  logic [PIN_W-1:0]  lookupPin,
  input  logic [MAP_W-1:0]  pinMap,
  output logic [PIRQ_W-1:0] lookupPirq
);
  always_comb begin
    int devIdx;
    int sum;
    devIdx = int'(lookupDev) - DEV_FIRST;
    sum    = int'(lookupDev) + int'(lookupPin);
    if (devIdx >= 0 && devIdx < DEV_COUNT)
      lookupPirq = pinMap[(devIdx*PIN_COUNT + int'(lookupPin))*PIRQ_W +: PIRQ_W];
    else
      lookupPirq = PIRQ_W'(HALF_PIRQ + (sum % HALF_PIRQ));
  end
endmodule

// File: rtl/pirq_route_top.sv
module pirq_route_top
  import pirq_route_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [7:0]           addr,
  input  logic [31:0]          wrData,
  input  logic [3:0]           byteEn,
  output logic [31:0]          rdData,
  output logic                 rdValid,
  output logic [83:0]          pinMap,
  input  logic [4:0]           lookupDev,
  input  logic [1:0]           lookupPin,
  output logic [2:0]           lookupPirq,
  output logic                 routeChanged
);
  winStrobe_t strobe;

  pirq_route_ctrl #(.ADDR_W(8)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .byteEn(byteEn), .strobe(strobe), .routeChanged(routeChanged),
    .rdValid(rdValid)
  );

  pirq_route_regs uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .rdData(rdData), .pinMap(pinMap)
  );

  pirq_route_lookup uLookup (
    .lookupDev(lookupDev), .lookupPin(lookupPin), .pinMap(pinMap),
    .lookupPirq(lookupPirq)
  );
endmodule

// File: rtl/pirq_route_chk.sv
module pirq_route_chk
  import pirq_route_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [MAP_W-1:0]  pinMap,
  input logic [DEV_W-1:0]  lookupDev,
  input logic [1:0]        lookupPin,
  input logic [PIRQ_W-1:0] lookupPirq,
  input logic              routeChanged,
  input logic              rdValid
);
  logic              inRange;
  logic [PIRQ_W-1:0] mapSlice;
  always_comb begin
    int idx;
    idx = int'(lookupDev) - DEV_FIRST;
    inRange  = (idx >= 0) && (idx < DEV_COUNT);
    mapSlice = '0;
    if (inRange) mapSlice = pinMap[(idx*PIN_COUNT + int'(lookupPin))*PIRQ_W +: PIRQ_W];
  end

  AST_NOTIFY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> routeChanged); // R10
  AST_NOTIFY_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> !routeChanged); // R10
  AST_READ_VALID: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid); // R11
  AST_READ_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid); // R11
  AST_MAP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(pinMap)); // R7
  AST_SWIZZLE_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    !inRange |-> lookupPirq[PIRQ_W-1]); // R8
  AST_LOOKUP_AGREES: assert property (@(posedge clk) disable iff (!rstN)
    inRange |-> (lookupPirq == mapSlice)); // R9
endmodule

bind pirq_route_top pirq_route_chk uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .pinMap(pinMap),
  .lookupDev(lookupDev), .lookupPin(lookupPin), .lookupPirq(lookupPirq),
  .routeChanged(routeChanged), .rdValid(rdValid)
);

// File: tb/tb_pirq_route_top.sv
`timescale 1ns/1ps
module tb_pirq_route_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn, rdEn;
  logic [7:0]  addr;
  logic [31:0] wrData;
  logic [3:0]  byteEn;
  logic [31:0] rdData;
  logic        rdValid;
  logic [83:0] pinMap;
  logic [4:0]  lookupDev;
  logic [1:0]  lookupPin;
  logic [2:0]  lookupPirq;
  logic        routeChanged;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] model [16];

  always #2.5 clk = ~clk;

  pirq_route_top dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .byteEn(byteEn), .rdData(rdData), .rdValid(rdValid),
    .pinMap(pinMap), .lookupDev(lookupDev), .lookupPin(lookupPin),
    .lookupPirq(lookupPirq), .routeChanged(routeChanged)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void modelReset();
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    for (int d = 0; d < 7; d++) begin
      if (d != 5) begin
        model[2*d] = 8'h10;
        model[2*d+1] = 8'h32;
      end
    end
  endfunction

  function automatic void modelWrite(input logic [7:0] a, input logic [31:0] dat,
                                     input logic [3:0] be);
    for (int k = 0; k < 4; k++) begin
      int t;
      t = int'(a[3:0]) + k;
      if (t < 16 && be[k] && t != 10 && t != 11) model[t] = dat[8*k +: 8];
    end
  endfunction

  function automatic logic [31:0] modelRead(input logic [7:0] a);
    logic [31:0] r;
    r = '0;
    for (int k = 0; k < 4; k++) begin
      int t;
      t = int'(a[3:0]) + k;
      if (t < 16) r[8*k +: 8] = model[t];
    end
    return r;
  endfunction

  function automatic logic [2:0] expLine(input int dev, input int pin);
    if (dev == 30) return 3'(4 + pin);
    if (dev >= 25 && dev <= 31) begin
      logic [15:0] rv;
      rv = {model[2*(dev-25)+1], model[2*(dev-25)]};
      return rv[4*pin +: 3];
    end
    return 3'(((dev + pin) % 4) + 4);
  endfunction

  function automatic logic [83:0] expMap();
    logic [83:0] m;
    for (int d = 0; d < 7; d++)
      for (int p = 0; p < 4; p++) m[(d*4+p)*3 +: 3] = expLine(d + 25, p);
    return m;
  endfunction

  task automatic doWrite(input logic [7:0] a, input logic [31:0] dat,
                         input logic [3:0] be);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = dat; byteEn = be;
    @(negedge clk);
    wrEn = 1'b0; byteEn = 4'h0;
    modelWrite(a, dat, be);
    check(routeChanged === 1'b1, "R10 pulse after write", 128'(routeChanged), 128'd1);
    check(pinMap === expMap(), "R7 decoded map", 128'(pinMap), 128'(expMap()));
    @(negedge clk);
    check(routeChanged === 1'b0, "R10 pulse one cycle", 128'(routeChanged), 128'd0);
  endtask

  task automatic doRead(input logic [7:0] a, input string req);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    check(rdValid === 1'b1, "R11 rdValid", 128'(rdValid), 128'd1);
    check(rdData === modelRead(a), req, 128'(rdData), 128'(modelRead(a)));
  endtask

  task automatic checkLookups(input string req);
    for (int d = 0; d < 32; d++) begin
      for (int p = 0; p < 4; p++) begin
        lookupDev = 5'(d); lookupPin = 2'(p);
        #0.5;
        check(lookupPirq === expLine(d, p), req, 128'(lookupPirq), 128'(expLine(d, p)));
      end
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] preRead;
    void'($urandom(32'h5EED));
    rstN = 1'b0; wrEn = 0; rdEn = 0; addr = 0; wrData = 0; byteEn = 0;
    lookupDev = 0; lookupPin = 0;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(routeChanged === 1'b0, "R1 routeChanged low", 128'(routeChanged), 128'd0);
    check(rdValid === 1'b0, "R1 rdValid low", 128'(rdValid), 128'd0);
    check(pinMap === expMap(), "R1 default map", 128'(pinMap), 128'(expMap()));
    for (int a = 0; a < 16; a += 2) doRead(8'(a), "R1 reset contents");
    checkLookups("R8 R9 lookup after reset");

    // R2: little-endian byte placement for device 27 (bytes 4,5)
    doWrite(8'h04, 32'h0000_4567, 4'b0011);
    doRead(8'h04, "R2 layout dev27");
    lookupDev = 5'd27; lookupPin = 2'd3; #0.5;
    check(lookupPirq === 3'd4, "R2 pin D nibble", 128'(lookupPirq), 128'd4);

    // R3: byte enables
    doWrite(8'h00, 32'hAABB_CCDD, 4'b0101);
    doRead(8'h00, "R3 byte enables");

    // R4: address masking
    doWrite(8'hF6, 32'h1122_3344, 4'b1111);
    doRead(8'h06, "R4 masked address");

    // R5: clipping at the end of the window, no wrap to byte 0
    doWrite(8'h0E, 32'h9988_7766, 4'b1111);
    doRead(8'h0E, "R5 clipped read");
    doRead(8'h00, "R5 no wrap");

    // R6: device 30 hard-wired
    doWrite(8'h0A, 32'hFFFF_FFFF, 4'b1111);
    doRead(8'h08, "R6 dev30 reads zero");
    for (int p = 0; p < 4; p++) begin
      lookupDev = 5'd30; lookupPin = 2'(p); #0.5;
      check(lookupPirq === 3'(4 + p), "R6 dev30 fixed lines", 128'(lookupPirq), 128'(4 + p));
    end

    // R7: reserved nibble bit stored but ignored
    doWrite(8'h02, 32'h0000_FE9A, 4'b0011);
    doRead(8'h02, "R7 bit3 readback");
    lookupDev = 5'd26; lookupPin = 2'd0; #0.5;
    check(lookupPirq === 3'd2, "R7 bit3 ignored", 128'(lookupPirq), 128'd2);

    // R11: read and write in the same cycle returns old data
    preRead = modelRead(8'h0C);
    @(negedge clk);
    wrEn = 1'b1; rdEn = 1'b1; addr = 8'h0C; wrData = 32'h5A5A_5A5A; byteEn = 4'hF;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0; byteEn = 4'h0;
    modelWrite(8'h0C, 32'h5A5A_5A5A, 4'hF);
    check(rdData === preRead, "R11 read before write", 128'(rdData), 128'(preRead));
    check(routeChanged === 1'b1, "R10 pulse with read", 128'(routeChanged), 128'd1);
    doRead(8'h0C, "R11 data after write");

    // random traffic
    for (int i = 0; i < 400; i++) begin
      logic [7:0]  ra;
      logic [31:0] rd;
      logic [3:0]  rb;
      ra = 8'($urandom); rd = $urandom; rb = 4'($urandom);
      if ($urandom % 2 == 0) doWrite(ra, rd, rb);
      else doRead(ra, "R2 R3 R5 random read");
      if (i % 50 == 0) checkLookups("R8 R9 random lookup");
    end
    checkLookups("R8 R9 final lookup");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule